// File: doc/BRIEF.md
# Bus Operation Timeout Monitor

This block watches a single outstanding bus operation for one channel. A one-cycle start pulse opens a monitoring window. A one-cycle done pulse closes it. If the done pulse does not arrive in time, the block raises a one-cycle timeout pulse and sets a sticky timeout flag. The flag stays set until a clear strobe removes it.

The time limit is built in two stages. A coarse prescaler divides the clock by one of three power-of-two ratios, and a fourth code switches monitoring off. A tick counter then counts 4, 8, 16 up to 512 prescaled ticks. The limit in clock cycles is the product of the two.

The three divide ratios are parameters, given as base-2 logarithms (defaults 8, 16 and 24), so a testbench can shrink them. The prescale and tick selects are assumed to stay steady while an operation is outstanding.

Top module: `busop_watchdog`

## Requirements
- R1: While `rst_n` is sampled low, and on the first cycle after release, `timeout_pulse` and `timeout_flag` are 0.
- R2: Let E0 be the clock edge that samples `op_start` high. If no `op_done` or new `op_start` follows, `timeout_pulse` is high in exactly the cycle after edge E(N), where N = divider × tick count.
- R3: The prescale select encodes the divider as follows: 0 = monitoring off, 1 = 2^DIV_A_LOG2, 2 = 2^DIV_B_LOG2, 3 = 2^DIV_C_LOG2.
- R4: Tick select code n gives a tick count of 4 << n, so codes 0..7 give 4..512.
- R5: With prescale select 0, no timeout pulse is issued and the flag is not set, however long the operation stays open.
- R6: The timeout pulse lasts one cycle and ends the window. No further pulse follows without a new `op_start`.
- R7: When the timeout pulse appears, `timeout_flag` is high in the same cycle. It stays high through a later `op_done`, until it is cleared.
- R8: `flag_clr` sampled high clears the flag on that edge. If an expiry happens on the same edge, the expiry wins and the flag stays set.
- R9: If `op_done` is sampled on the very edge where the window would expire, no pulse is issued and the flag is not set.
- R10: `op_start` during an open window restarts both counters, so expiry is measured from the latest start.
- R11: `op_done` sampled before expiry closes the window, and no timeout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale_sel | input | 2 | Divider code (0 = off) |
| tick_sel | input | 3 | Tick count code, count = 4 << code |
| op_start | input | 1 | One-cycle pulse: operation issued |
| op_done | input | 1 | One-cycle pulse: operation completed |
| flag_clr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| timeout_pulse | output | 1 | One-cycle expiry indication |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
Two pairs of events can coincide on one edge.

The first pair is completion and expiry. The bench raises `op_done` so that it is sampled on exactly the edge N cycles after the start. It then expects neither a pulse nor a flag, in that cycle or after.

The second pair is the clear strobe and expiry. The bench holds `flag_clr` on the expiry edge and expects the flag to read back set. A separate clear afterwards must then remove it.

// File: rtl/busop_wd_pkg.sv
// Package: shared encodings and widths for the bus operation timeout monitor.
// Assumes: select codes are binary; the tick count is a power of two.
package busop_wd_pkg;

    localparam int PS_W           = 2;
    localparam int TS_W           = 3;
    localparam int TICK_BASE_LOG2 = 2;
    localparam int TICK_CNT_W     = TICK_BASE_LOG2 + (1 << TS_W) - 1;

    typedef enum logic [PS_W-1:0] {
        PS_OFF   = 2'd0,
        PS_DIV_A = 2'd1,
        PS_DIV_B = 2'd2,
        PS_DIV_C = 2'd3
    } ps_code_t;

    // Last tick index of a window: (4 << code) - 1.
    function automatic logic [TICK_CNT_W-1:0] tick_last_idx(input logic [TS_W-1:0] code);
        logic [TICK_CNT_W:0] full;
        full = (TICK_CNT_W+1)'(1) << (TICK_BASE_LOG2 + int'(code));
        return TICK_CNT_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/busop_prescaler.sv
// Module: coarse prescaler producing one tick every 2^k clocks.
// Assumes: ps_sel is steady while run is high; code PS_OFF holds the count at zero.
module busop_prescaler
    import busop_wd_pkg::*;
#(
    parameter int DIV_A_LOG2 = 8,
    parameter int DIV_B_LOG2 = 16,
    parameter int DIV_C_LOG2 = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick,
    output logic            enabled
);

    localparam int MAX_AB = (DIV_A_LOG2 > DIV_B_LOG2) ? DIV_A_LOG2 : DIV_B_LOG2;
    localparam int CNT_W  = (MAX_AB > DIV_C_LOG2) ? MAX_AB : DIV_C_LOG2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wrap_mask;
    ps_code_t         code;

    assign code    = ps_code_t'(ps_sel);
    assign enabled = (code != PS_OFF);

    // Purpose: pick the wrap mask that matches the selected divider.
    always_comb begin
        case (code)
            PS_DIV_A: wrap_mask = {CNT_W{1'b1}} >> (CNT_W - DIV_A_LOG2);
            PS_DIV_B: wrap_mask = {CNT_W{1'b1}} >> (CNT_W - DIV_B_LOG2);
            PS_DIV_C: wrap_mask = {CNT_W{1'b1}} >> (CNT_W - DIV_C_LOG2);
            default:  wrap_mask = '0;
        endcase
    end

    assign tick = run && enabled && !restart && (cnt_q == wrap_mask);

    // Purpose: count clocks within one prescaled period, zero when idle or off.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || !enabled) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/busop_tick_counter.sv
// Module: counts prescaled ticks and flags the final tick of the window.
// Assumes: tick is only high while the window is open and enabled.
module busop_tick_counter
    import busop_wd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic            tick,
    input  logic [TS_W-1:0] ts_sel,
    output logic            last_tick
);

    logic [TICK_CNT_W-1:0] cnt_q;
    logic [TICK_CNT_W-1:0] last_idx;

    assign last_idx  = tick_last_idx(ts_sel);
    assign last_tick = tick && (cnt_q == last_idx);

    // Purpose: advance once per prescaled tick, restart on a new window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/busop_flag.sv
// Module: registered timeout pulse and sticky flag with write-one-to-clear.
// Assumes: expire is a single-cycle qualified request.
module busop_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic pulse,
    output logic flag
);

    // Purpose: register the expiry pulse; a set outranks a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pulse <= expire;
            if (expire) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/busop_watchdog.sv
// Module: top of the bus operation timeout monitor for one channel.
// Assumes: op_start/op_done are single-cycle pulses; selects are steady during a window.
// A start outranks a done on the same edge; a done outranks an expiry.
module busop_watchdog
    import busop_wd_pkg::*;
#(
    parameter int DIV_A_LOG2 = 8,
    parameter int DIV_B_LOG2 = 16,
    parameter int DIV_C_LOG2 = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] prescale_sel,
    input  logic [2:0] tick_sel,
    input  logic       op_start,
    input  logic       op_done,
    input  logic       flag_clr,
    output logic       timeout_pulse,
    output logic       timeout_flag
);

    logic active_q;
    logic pre_tick;
    logic pre_en;
    logic last_tick;
    logic expire;

    assign expire = last_tick && !op_done && !op_start;

    // Purpose: track whether an operation window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (op_start) begin
            active_q <= 1'b1;
        end else if (op_done || expire) begin
            active_q <= 1'b0;
        end
    end

    busop_prescaler #(
        .DIV_A_LOG2 (DIV_A_LOG2),
        .DIV_B_LOG2 (DIV_B_LOG2),
        .DIV_C_LOG2 (DIV_C_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active_q),
        .restart (op_start),
        .ps_sel  (prescale_sel),
        .tick    (pre_tick),
        .enabled (pre_en)
    );

    busop_tick_counter u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active_q && pre_en),
        .restart   (op_start),
        .tick      (pre_tick),
        .ts_sel    (tick_sel),
        .last_tick (last_tick)
    );

    busop_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clr    (flag_clr),
        .pulse  (timeout_pulse),
        .flag   (timeout_flag)
    );

endmodule

// File: rtl/busop_watchdog_chk.sv
// Module: assertion checker attached to busop_watchdog through bind.
// Assumes: observes only the top-level ports.
module busop_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] prescale_sel,
    input logic [2:0] tick_sel,
    input logic       op_start,
    input logic       op_done,
    input logic       flag_clr,
    input logic       timeout_pulse,
    input logic       timeout_flag
);

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> timeout_flag);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !flag_clr) |=> timeout_flag);

    p_flag_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_flag) |-> $past(flag_clr));

    p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_sel == 2'd0) |=> !timeout_pulse);

    p_done_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || op_start) |=> !timeout_pulse);

    p_tick_sel_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(tick_sel));

endmodule

bind busop_watchdog busop_watchdog_chk u_chk (.*);

// File: tb/busop_watchdog_test.sv
module busop_watchdog_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // Columns: prescale code, tick code, expected window in clocks (dividers 2, 4, 8).
    localparam int VEC [0:NV-1][0:2] = '{
        '{1, 0,    8}, '{1, 3,   64}, '{2, 1,   32}, '{2, 5,  512},
        '{3, 2,  128}, '{3, 7, 4096}, '{1, 7, 1024}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] prescale_sel = 2'd1;
    logic [2:0] tick_sel = 3'd0;
    logic       op_start = 1'b0;
    logic       op_done = 1'b0;
    logic       flag_clr = 1'b0;
    logic       timeout_pulse;
    logic       timeout_flag;

    int checks = 0;
    int errors = 0;
    int pulses_seen = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busop_watchdog #(.DIV_A_LOG2(1), .DIV_B_LOG2(2), .DIV_C_LOG2(3)) uut (
        .clk(clk), .rst_n(rst_n), .prescale_sel(prescale_sel), .tick_sel(tick_sel),
        .op_start(op_start), .op_done(op_done), .flag_clr(flag_clr),
        .timeout_pulse(timeout_pulse), .timeout_flag(timeout_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (timeout_pulse) pulses_seen++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic start_op();
        op_start = 1'b1;
        step();
        op_start = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        steps(3);
        check(timeout_pulse == 0 && timeout_flag == 0, "R1 reset outputs", {timeout_pulse, timeout_flag}, 0);
        rst_n = 1'b1;
        step();
        check(timeout_pulse == 0 && timeout_flag == 0, "R1 after release", {timeout_pulse, timeout_flag}, 0);

        // Table walk: R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            prescale_sel = 2'(VEC[v][0]);
            tick_sel     = 3'(VEC[v][1]);
            start_op();
            pulses_seen = 0;
            steps(VEC[v][2] - 1);
            check(pulses_seen == 0 && timeout_pulse == 0, "R2 R3 R4 early pulse", pulses_seen, 0);
            step();
            check(timeout_pulse == 1, "R2 R3 R4 pulse at window end", timeout_pulse, 1);
            check(timeout_flag == 1, "R7 flag with pulse", timeout_flag, 1);
            pulses_seen = 0;
            steps(VEC[v][2] + 4);
            check(pulses_seen == 0, "R6 no repeat pulse", pulses_seen, 0);
            check(timeout_flag == 1, "R7 flag holds", timeout_flag, 1);
            clear_flag();
            check(timeout_flag == 0, "R8 clear", timeout_flag, 1'b0);
        end

        // R5: disabled code
        prescale_sel = 2'd0; tick_sel = 3'd0;
        start_op();
        pulses_seen = 0;
        steps(5000);
        check(pulses_seen == 0 && timeout_flag == 0, "R5 off never times out", pulses_seen, 0);
        op_done = 1'b1; step(); op_done = 1'b0;

        // R9: done on the expiry edge (window 8)
        prescale_sel = 2'd1; tick_sel = 3'd0;
        start_op();
        pulses_seen = 0;
        steps(7);
        op_done = 1'b1; step(); op_done = 1'b0;
        steps(20);
        check(pulses_seen == 0 && timeout_flag == 0, "R9 done wins", pulses_seen + timeout_flag, 0);

        // R11: early done
        start_op();
        pulses_seen = 0;
        steps(3);
        op_done = 1'b1; step(); op_done = 1'b0;
        steps(20);
        check(pulses_seen == 0 && timeout_flag == 0, "R11 early done", pulses_seen + timeout_flag, 0);

        // R7: late done leaves flag set
        start_op();
        steps(8);
        check(timeout_pulse == 1, "R2 window 8", timeout_pulse, 1);
        op_done = 1'b1; step(); op_done = 1'b0;
        step();
        check(timeout_flag == 1, "R7 late done keeps flag", timeout_flag, 1);
        clear_flag();

        // R8: clear on the expiry edge, set wins
        start_op();
        steps(7);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check(timeout_pulse == 1 && timeout_flag == 1, "R8 set beats clear", timeout_flag, 1);
        clear_flag();
        check(timeout_flag == 0, "R8 later clear", timeout_flag, 0);

        // R10: restart mid-window
        start_op();
        steps(5);
        start_op();
        pulses_seen = 0;
        steps(7);
        check(pulses_seen == 0 && timeout_pulse == 0, "R10 no pulse from first start", pulses_seen, 0);
        step();
        check(timeout_pulse == 1, "R10 pulse from latest start", timeout_pulse, 1);
        clear_flag();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule